// File: doc/BRIEF.md
# DMA channel request and transfer sequencer

This block is the control core of a single DMA channel. Software programs a control register and a transfer count through a small register port. The channel then waits for a trigger, which can be a level or a falling edge on an active-low external request line, a falling edge from an on-chip peripheral, or an automatic internal trigger. For each trigger it runs one transfer unit on a simple bus handshake. Each unit is one beat of byte, 16-bit or 32-bit size, or four back-to-back 32-bit beats for a 16-byte unit.

The count drops by one per completed unit. When the count reaches zero, an end flag is set and the channel stops until software clears the flag. If the interrupt enable is set, the end flag drives the interrupt output. In cycle-steal mode the bus request is released after every unit. In burst mode it is held until the count is exhausted. The parameter `HAS_SEL` decides whether this channel implements the request-sampling select bit. Address generation, channel arbitration and memory live outside the block.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, the control word (address 0) and the count (address 1) read 0, and `bus_req_o` and `irq_o` are low.
- R2: Control bit 7 always reads 0, whatever is written to it. Bits above 7 also read 0.
- R3: Control bit 6 selects request sampling: 0 is low level, 1 is falling edge. With `HAS_SEL=1` it can be written and read back. With `HAS_SEL=0` writes to it are ignored and it reads 0.
- R4: With `src_i=0` (external) and bit 6 = 0, the channel starts units while the synchronized request is held low, and never starts one while the request stays high.
- R5: In edge mode (external source with bit 6 = 1, or `src_i=1` peripheral whatever bit 6 holds), each falling edge starts exactly one unit. Edges that arrive while the channel is busy are latched as a single pending request.
- R6: With `src_i` = 2 or 3 (auto), an enabled channel starts units with no request input and repeats them until the count is exhausted.
- R7: Control bits 4:3 select the size (00 byte, 01 word, 10 longword, 11 16-byte unit). `size_o` gives the same code per beat, except that a 16-byte unit shows code 10 and takes four completed beats. A beat completes in a cycle where `bus_req_o`, `bus_gnt_i` and `bus_done_i` are all high.
- R8: Control bit 5 selects the bus mode. With 0 (cycle-steal), `bus_req_o` drops for at least one cycle after every unit. With 1 (burst), it stays high from the first unit until the count reaches 0.
- R9: The count (address 1) decrements once per completed unit. When it reaches 0, control bit 1 (end flag) is set and no new unit starts until the flag is cleared by writing 0 to bit 1. Writing 1 to bit 1 has no effect.
- R10: `irq_o` is high exactly while the end flag and control bit 2 (interrupt enable) are both 1.
- R11: While `bus_req_o` is high, writes to control bits 6:2 and to the count are ignored. Control bit 0 (channel enable) can be written at any time. No unit starts while bit 0 is 0 or the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 count |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` |
| req_ni | input | 1 | Asynchronous active-low transfer request |
| src_i | input | 2 | Request source: 0 external, 1 peripheral, 2/3 auto |
| bus_req_o | output | 1 | Bus request, high while a unit is in progress |
| bus_gnt_i | input | 1 | Bus grant |
| bus_done_i | input | 1 | Beat completion |
| size_o | output | 2 | Size code of the current beat |
| irq_o | output | 1 | Transfer-end interrupt |

## Verification
The bench builds the main instance with `HAS_SEL=1`, which reaches both the level and the edge sampling paths on the external source. It also builds a second instance with `HAS_SEL=0`, so that the ignored write and the zero read-back of the select bit can be observed at the register port. Both use 16-bit data and count, which keeps short counts fast. Random grant and completion stalls vary the unit and beat timing. A directed phase holds completion off to stack several edges inside one busy unit.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_QUAD = 2'b11
  } xfer_size_e;

  typedef struct packed {
    logic       sel_edge;
    logic       burst;
    xfer_size_e size;
    logic       ie;
  } ctrl_t;

  localparam int unsigned QUAD_BEATS = 4;
  localparam int unsigned B_SEL   = 6;
  localparam int unsigned B_BURST = 5;
  localparam int unsigned B_SIZE  = 3;
  localparam int unsigned B_IE    = 2;
  localparam int unsigned B_END   = 1;
  localparam int unsigned B_EN    = 0;

  localparam logic [1:0] SRC_EXT    = 2'd0;
  localparam logic [1:0] SRC_PERIPH = 2'd1;
endpackage

// File: rtl/dma_req_detect.sv
module dma_req_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  input  logic edge_mode_i,
  input  logic take_i,
  output logic level_o,
  output logic pend_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, pend_q;
  logic fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], req_ni};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall    = prev_q & ~sync_q[SYNC_STAGES-1];
  assign level_o = ~sync_q[SYNC_STAGES-1];

  // one pending slot; a new edge in the take cycle survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pend_q <= 1'b0;
    else if (!edge_mode_i) pend_q <= 1'b0;
    else if (fall)         pend_q <= 1'b1;
    else if (take_i)       pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_seq_pkg::*;
#(
  parameter bit          HAS_SEL = 1'b1,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CNT_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              unit_done_i,
  output ctrl_t             ctrl_o,
  output logic              en_o,
  output logic              end_o,
  output logic              cnt_zero_o,
  output logic              cnt_last_o,
  output logic [DATA_W-1:0] rdata_o
);
  ctrl_t            ctrl_q;
  logic             en_q, end_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
      end_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (unit_done_i) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_last_o) end_q <= 1'b1;
      end
      if (we_i && !addr_i) begin
        en_q <= wdata_i[B_EN];
        if (!wdata_i[B_END]) end_q <= 1'b0;
        if (!busy_i) begin
          ctrl_q.sel_edge <= HAS_SEL ? wdata_i[B_SEL] : 1'b0;
          ctrl_q.burst    <= wdata_i[B_BURST];
          ctrl_q.size     <= xfer_size_e'(wdata_i[B_SIZE+1:B_SIZE]);
          ctrl_q.ie       <= wdata_i[B_IE];
        end
      end
      if (we_i && addr_i && !busy_i) cnt_q <= wdata_i[CNT_W-1:0];
    end
  end

  assign ctrl_o     = ctrl_q;
  assign en_o       = en_q;
  assign end_o      = end_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign cnt_last_o = (cnt_q == CNT_W'(1));

  always_comb begin
    rdata_o = '0;
    if (addr_i) rdata_o[CNT_W-1:0] = cnt_q;
    else begin
      rdata_o[B_SEL]             = ctrl_q.sel_edge;
      rdata_o[B_BURST]           = ctrl_q.burst;
      rdata_o[B_SIZE+1:B_SIZE]   = ctrl_q.size;
      rdata_o[B_IE]              = ctrl_q.ie;
      rdata_o[B_END]             = end_q;
      rdata_o[B_EN]              = en_q;
    end
  end

  // R11
  mode_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> $stable(ctrl_q));
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       burst_i,
  input  xfer_size_e size_i,
  input  logic       cnt_last_i,
  input  logic       gnt_i,
  input  logic       done_i,
  output logic       busy_o,
  output logic [1:0] size_o,
  output logic       unit_done_o
);
  localparam int unsigned BW = $clog2(QUAD_BEATS);

  logic          busy_q;
  logic [BW-1:0] beat_q;
  logic          beat_ok, last_beat;

  assign beat_ok     = busy_q & gnt_i & done_i;
  assign last_beat   = (size_i != SZ_QUAD) || (beat_q == BW'(QUAD_BEATS-1));
  assign unit_done_o = beat_ok & last_beat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      beat_q <= '0;
    end else if (!busy_q) begin
      busy_q <= start_i;
      beat_q <= '0;
    end else if (beat_ok) begin
      if (last_beat) begin
        beat_q <= '0;
        busy_q <= burst_i && !cnt_last_i;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign size_o = (size_i == SZ_QUAD) ? SZ_LONG : size_i;

  // R8
  burst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_done_o && burst_i && !cnt_last_i) |=> busy_q);
  // R8
  steal_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_done_o && !burst_i) |=> !busy_q);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter bit          HAS_SEL     = 1'b1,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              req_ni,
  input  logic [1:0]        src_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  input  logic              bus_done_i,
  output logic [1:0]        size_o,
  output logic              irq_o
);
  ctrl_t ctrl;
  logic  en, end_flag, cnt_zero, cnt_last, busy, unit_done;
  logic  level, pend, is_auto, edge_mode, trig, start;

  assign is_auto   = src_i[1];
  // peripheral source forces edge sampling
  assign edge_mode = !is_auto && ((src_i == SRC_PERIPH) || ctrl.sel_edge);
  assign trig      = is_auto || (edge_mode ? pend : level);
  assign start     = !busy && en && !end_flag && !cnt_zero && trig;

  dma_req_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk_i, .rst_ni, .req_ni,
    .edge_mode_i(edge_mode),
    .take_i     (start),
    .level_o    (level),
    .pend_o     (pend)
  );

  dma_chan_regs #(.HAS_SEL(HAS_SEL), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .busy_i     (busy),
    .unit_done_i(unit_done),
    .ctrl_o     (ctrl),
    .en_o       (en),
    .end_o      (end_flag),
    .cnt_zero_o (cnt_zero),
    .cnt_last_o (cnt_last),
    .rdata_o    (reg_rdata_o)
  );

  dma_xfer_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i    (start),
    .burst_i    (ctrl.burst),
    .size_i     (ctrl.size),
    .cnt_last_i (cnt_last),
    .gnt_i      (bus_gnt_i),
    .done_i     (bus_done_i),
    .busy_o     (busy),
    .size_o     (size_o),
    .unit_done_o(unit_done)
  );

  assign bus_req_o = busy;
  assign irq_o     = end_flag & ctrl.ie;

  // R9
  end_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_flag |-> !bus_req_o);
  // R6
  auto_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_auto && en && !end_flag && !cnt_zero && !busy) |=> bus_req_o);
endmodule

// File: tb/sim_dma_chan_seq.sv
module sim_dma_chan_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        req_n = 1'b1;
  logic [1:0]  src = 2'd2;
  logic        bus_req, gnt = 1'b0, done = 1'b0, irq;
  logic [1:0]  size;
  logic        we1 = 1'b0;
  logic [15:0] rdata1;
  logic        bus_req1, irq1;
  logic [1:0]  size1;

  int checks = 0, errors = 0;
  int beats = 0, rises = 0, bad_size = 0;
  logic [1:0] exp_enc = 2'b00;
  bit done_en = 1'b1;
  bit p_d = 0, p_g = 0, p_r = 0;
  logic [1:0] p_sz = 0;
  int unsigned seed_sink;

  always #5 clk = ~clk;

  dma_chan_seq #(.HAS_SEL(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .req_ni(req_n), .src_i(src),
    .bus_req_o(bus_req), .bus_gnt_i(gnt), .bus_done_i(done),
    .size_o(size), .irq_o(irq));

  dma_chan_seq #(.HAS_SEL(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we1), .reg_addr_i(1'b0),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata1), .req_ni(1'b1), .src_i(2'd0),
    .bus_req_o(bus_req1), .bus_gnt_i(1'b0), .bus_done_i(1'b0),
    .size_o(size1), .irq_o(irq1));

  // bus responder and monitor
  initial begin
    forever begin
      @(negedge clk);
      if (p_d && p_g && p_r) begin
        beats++;
        if (p_sz != exp_enc) bad_size++;
      end
      if (bus_req && !p_r) rises++;
      p_r  = bus_req;
      p_sz = size;
      p_g  = ($urandom % 4) != 0;
      p_d  = done_en && (($urandom % 2) == 1);
      gnt  = p_g;
      done = p_d;
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); #1;
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk); #2;
    addr = a; #1;
    d = rdata;
  endtask

  task automatic clr_mon();
    @(negedge clk); #1;
    beats = 0; rises = 0; bad_size = 0;
  endtask

  task automatic wait_end(output bit ok);
    logic [15:0] v;
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      rd(1'b0, v);
      if (v[1]) begin ok = 1; break; end
    end
  endtask

  task automatic fall_pulse();
    @(negedge clk); req_n = 1'b1;
    repeat (4) @(negedge clk);
    req_n = 1'b0;
    repeat (4) @(negedge clk);
    req_n = 1'b1;
  endtask

  function automatic logic [15:0] ctrl_word(bit sel, bit burst, logic [1:0] sz,
                                            bit ie, bit en);
    return {9'd0, sel, burst, sz, ie, 1'b0, en};
  endfunction

  function automatic logic [1:0] enc_of(logic [1:0] sz);
    return (sz == 2'b11) ? 2'b10 : sz;
  endfunction

  function automatic int beats_of(logic [1:0] sz, int n);
    return (sz == 2'b11) ? 4 * n : n;
  endfunction

  logic [15:0] v;
  bit ok;

  initial begin
    seed_sink = $urandom(32'd1977);
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(1'b0, v); chk("R1 ctrl", int'(v), 0);
    rd(1'b1, v); chk("R1 count", int'(v), 0);
    chk("R1 bus_req", int'(bus_req), 0);
    chk("R1 irq", int'(irq), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2, R3 register bits
    src = 2'd0;
    wr(1'b0, 16'hFFC0);
    rd(1'b0, v);
    chk("R2 bit7", int'(v[7]), 0);
    chk("R2 high bits", int'(v[15:8]), 0);
    chk("R3 sel has", int'(v[6]), 1);
    @(negedge clk); #1; wdata = 16'h00C0; we1 = 1'b1;
    @(negedge clk); #1; we1 = 1'b0; #1;
    chk("R3 sel absent", int'(rdata1[6]), 0);
    chk("R2 bit7 absent", int'(rdata1[7]), 0);
    wr(1'b0, 16'h0000);

    // R4 level high: no start
    clr_mon();
    wr(1'b1, 16'd3);
    wr(1'b0, ctrl_word(0, 0, 2'b00, 0, 1));
    repeat (40) @(negedge clk);
    chk("R4 no start high", rises, 0);
    rd(1'b1, v); chk("R4 count kept", int'(v), 3);
    // R4 level low: runs all units
    exp_enc = 2'b00;
    req_n = 1'b0;
    wait_end(ok);
    chk("R4 end", int'(ok), 1);
    chk("R4 units", rises, 3);
    chk("R7 beats byte", beats, 3);
    req_n = 1'b1;
    wr(1'b0, 16'h0000);

    // R9 flag blocks restart, R11 enable/count zero
    wr(1'b1, 16'd2);
    clr_mon();
    src = 2'd2;
    wr(1'b0, ctrl_word(0, 0, 2'b01, 1, 0));
    repeat (20) @(negedge clk);
    chk("R11 disabled no start", rises, 0);
    exp_enc = 2'b01;
    wr(1'b0, ctrl_word(0, 0, 2'b01, 1, 1));
    wait_end(ok);
    chk("R10 irq on end", int'(irq), 1);
    wr(1'b1, 16'd2);
    wr(1'b0, ctrl_word(0, 0, 2'b01, 1, 1) | 16'h0002);
    clr_mon();
    repeat (20) @(negedge clk);
    chk("R9 flag holds", rises, 0);
    rd(1'b0, v); chk("R9 write1 no clear", int'(v[1]), 1);
    wr(1'b0, ctrl_word(0, 0, 2'b01, 1, 1));
    wait_end(ok);
    chk("R9 rerun units", rises, 2);
    rd(1'b1, v); chk("R9 count zero", int'(v), 0);
    wr(1'b0, ctrl_word(0, 0, 2'b01, 1, 0));
    chk("R10 irq clear", int'(irq), 0);

    // R5 edge stacking during busy, R11 writes ignored while busy
    src = 2'd0;
    done_en = 0;
    wr(1'b1, 16'd5);
    exp_enc = 2'b00;
    wr(1'b0, ctrl_word(1, 0, 2'b00, 0, 1));
    clr_mon();
    fall_pulse();
    repeat (4) @(negedge clk);
    chk("R5 started", int'(bus_req), 1);
    fall_pulse();
    fall_pulse();
    wr(1'b0, ctrl_word(1, 1, 2'b11, 1, 1));
    wr(1'b1, 16'd9);
    rd(1'b0, v); chk("R11 mode kept", int'(v[5:2]), 0);
    rd(1'b1, v); chk("R11 count kept", int'(v), 5);
    done_en = 1;
    repeat (60) @(negedge clk);
    chk("R5 units", rises, 2);
    rd(1'b1, v); chk("R5 count", int'(v), 3);
    wr(1'b0, 16'h0000);

    // R5 peripheral forces edge even with sel=0
    src = 2'd1;
    wr(1'b1, 16'd3);
    wr(1'b0, ctrl_word(0, 0, 2'b00, 0, 1));
    clr_mon();
    fall_pulse();
    req_n = 1'b0;
    repeat (60) @(negedge clk);
    chk("R5 periph one unit", rises, 1);
    rd(1'b1, v); chk("R5 periph count", int'(v), 2);
    req_n = 1'b1;
    wr(1'b0, 16'h0000);

    // random: auto and level, all sizes and modes
    for (int it = 0; it < 24; it++) begin
      logic [1:0] sz = 2'($urandom % 4);
      bit bm = 1'($urandom % 2);
      bit ie = 1'($urandom % 2);
      bit aut = 1'($urandom % 2);
      int n = 1 + int'($urandom % 4);
      src = aut ? 2'(2 + $urandom % 2) : 2'd0;
      req_n = aut ? 1'b1 : 1'b0;
      exp_enc = enc_of(sz);
      wr(1'b1, 16'(n));
      clr_mon();
      wr(1'b0, ctrl_word(0, bm, sz, ie, 1));
      wait_end(ok);
      repeat (3) @(negedge clk);
      chk("R6 end", int'(ok), 1);
      chk("R7 beats", beats, beats_of(sz, n));
      chk("R7 size code", bad_size, 0);
      chk("R8 bus grabs", rises, bm ? 1 : n);
      chk("R10 irq", int'(irq), int'(ie));
      rd(1'b1, v); chk("R9 count", int'(v), 0);
      req_n = 1'b1;
      wr(1'b0, 16'h0000);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule